// File: doc/BRIEF.md
# Fractional-Period Tick Generator

This block produces a periodic overflow pulse whose average period is a fraction of clock cycles. Typical use is a 1 ms system tick taken from a clock whose frequency is not a whole multiple of 1 kHz. An up-counter runs from a loaded start value to all-ones and then wraps. At each wrap it reloads either a short-period start value or a long-period start value.

The choice between the two start values comes from a signed error accumulator. While the accumulator is negative, the block loads the short-period start value and adds a positive correction. While the accumulator is zero or positive, it loads the long-period start value and adds a negative correction, held in two's complement. Over many ticks the accumulator stays near zero, and the ratio of short periods to long periods sets the fractional average.

Software programs the block through a plain write/read register port. It sets the two corrections, the two start values and the starting error, and it can also load the counter directly. A tick-enable input gates all counting. The port is control-only, so it has no handshake.

Top module: `frac_tick_gen`

## Requirements
- R1: After reset, every register reads zero and `ovf_o` is low.
- R2: Register addresses are 0 for the positive correction, 1 for the negative correction, 2 for the error accumulator, 3 for the short-period start value, 4 for the long-period start value and 5 for the counter. A write stores `wdata_i` at the next clock edge. `rdata_o` shows the addressed register in the same cycle. Addresses 6 and 7 read zero, and a write to them changes no register.
- R3: While `tick_en_i` is high and the counter is not all-ones, the counter rises by exactly one per clock.
- R4: `ovf_o` is high in exactly those cycles where `tick_en_i` is high and the counter is all-ones.
- R5: In an overflow cycle where the accumulator's top bit is 1, the next edge loads the counter with the short-period start value and adds the positive correction to the accumulator, modulo 2^32.
- R6: In an overflow cycle where the accumulator's top bit is 0, the next edge loads the counter with the long-period start value and adds the negative correction to the accumulator, modulo 2^32.
- R7: A software write to the accumulator wins over its update in the same cycle. A software write to the counter wins over a reload or an increment in the same cycle.
- R8: While `tick_en_i` is low and no write targets them, the counter and the accumulator keep their values and `ovf_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_en_i | input | 1 | Enables counting and the accumulator update |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| ovf_o | output | 1 | Overflow pulse, one cycle per counter wrap |

## Verification
The reload path is tried with three accumulator patterns:
- An error that swings across zero shows whether the block alternates correctly between the two start values and applies the matching correction.
- An error pinned deeply negative checks the polarity of the selection, because only the short period should ever appear.
- An error starting positive and stepping down through zero shows the exact ordering of the handover.

Directed cases then cover same-cycle software writes that collide with an overflow, gating by the tick enable, and the unmapped addresses.

// File: rtl/frac_tick_pkg.sv
package frac_tick_pkg;
  localparam int ADDR_W  = 3;
  localparam int NUM_CFG = 4;

  typedef enum logic [ADDR_W-1:0] {
    ADR_POS = 3'd0,
    ADR_NEG = 3'd1,
    ADR_ACC = 3'd2,
    ADR_SUB = 3'd3,
    ADR_OVR = 3'd4,
    ADR_CNT = 3'd5
  } addr_e;

  // Address of each plain configuration register, by bank index.
  function automatic logic [ADDR_W-1:0] cfg_addr(input int idx);
    case (idx)
      0:       return ADR_POS;
      1:       return ADR_NEG;
      2:       return ADR_SUB;
      default: return ADR_OVR;
    endcase
  endfunction
endpackage

// File: rtl/frac_tick_cfg.sv
module frac_tick_cfg
  import frac_tick_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     pos_inc_o,
  output logic [DW-1:0]     neg_inc_o,
  output logic [DW-1:0]     sub_val_o,
  output logic [DW-1:0]     ovr_val_o
);
  logic [DW-1:0] bank_q [NUM_CFG];

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_bank
    localparam logic [ADDR_W-1:0] MY_ADDR = cfg_addr(g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bank_q[g] <= '0;
      end else if (wr_en_i && (addr_i == MY_ADDR)) begin
        bank_q[g] <= wdata_i;
      end
    end
  end

  assign pos_inc_o = bank_q[0];
  assign neg_inc_o = bank_q[1];
  assign sub_val_o = bank_q[2];
  assign ovr_val_o = bank_q[3];
endmodule

// File: rtl/frac_tick_ctr.sv
module frac_tick_ctr #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_en_i,
  input  logic          sw_load_i,
  input  logic [DW-1:0] sw_val_i,
  input  logic [DW-1:0] reload_i,
  output logic [DW-1:0] cnt_o,
  output logic          at_max_o
);
  logic [DW-1:0] cnt_q;

  assign at_max_o = &cnt_q;
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (sw_load_i) begin
      cnt_q <= sw_val_i;
    end else if (tick_en_i) begin
      cnt_q <= at_max_o ? reload_i : cnt_q + DW'(1);
    end
  end
endmodule

// File: rtl/frac_tick_acc.sv
module frac_tick_acc #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic          sw_load_i,
  input  logic [DW-1:0] sw_val_i,
  input  logic [DW-1:0] pos_inc_i,
  input  logic [DW-1:0] neg_inc_i,
  output logic [DW-1:0] acc_o,
  output logic          pick_sub_o
);
  logic [DW-1:0] acc_q;
  logic [DW-1:0] addend;

  assign pick_sub_o = acc_q[DW-1];
  assign addend     = pick_sub_o ? pos_inc_i : neg_inc_i;
  assign acc_o      = acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
    end else if (sw_load_i) begin
      acc_q <= sw_val_i;
    end else if (step_i) begin
      acc_q <= acc_q + addend;
    end
  end
endmodule

// File: rtl/frac_tick_gen.sv
module frac_tick_gen
  import frac_tick_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              ovf_o
);
  logic [DW-1:0] pos_inc, neg_inc, sub_val, ovr_val;
  logic [DW-1:0] cnt_val, acc_val, reload_val;
  logic          at_max, pick_sub;
  logic          wr_acc, wr_cnt;

  assign wr_acc = wr_en_i && (addr_i == ADR_ACC);
  assign wr_cnt = wr_en_i && (addr_i == ADR_CNT);
  assign ovf_o  = tick_en_i && at_max;
  assign reload_val = pick_sub ? sub_val : ovr_val;

  frac_tick_cfg #(.DW(DW)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .pos_inc_o (pos_inc),
    .neg_inc_o (neg_inc),
    .sub_val_o (sub_val),
    .ovr_val_o (ovr_val)
  );

  frac_tick_ctr #(.DW(DW)) u_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_en_i (tick_en_i),
    .sw_load_i (wr_cnt),
    .sw_val_i  (wdata_i),
    .reload_i  (reload_val),
    .cnt_o     (cnt_val),
    .at_max_o  (at_max)
  );

  frac_tick_acc #(.DW(DW)) u_acc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (ovf_o),
    .sw_load_i  (wr_acc),
    .sw_val_i   (wdata_i),
    .pos_inc_i  (pos_inc),
    .neg_inc_i  (neg_inc),
    .acc_o      (acc_val),
    .pick_sub_o (pick_sub)
  );

  always_comb begin
    case (addr_i)
      ADR_POS: rdata_o = pos_inc;
      ADR_NEG: rdata_o = neg_inc;
      ADR_ACC: rdata_o = acc_val;
      ADR_SUB: rdata_o = sub_val;
      ADR_OVR: rdata_o = ovr_val;
      ADR_CNT: rdata_o = cnt_val;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/frac_tick_sva.sv
module frac_tick_sva
  import frac_tick_pkg::*;
#(
  parameter int DW = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_en_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DW-1:0]     wdata_i,
  input logic              ovf_o,
  input logic [DW-1:0]     cnt,
  input logic [DW-1:0]     acc,
  input logic [DW-1:0]     pos,
  input logic [DW-1:0]     neg,
  input logic [DW-1:0]     sub,
  input logic [DW-1:0]     ovr
);
  p_count_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_en_i && !ovf_o && !wr_en_i) |=> (cnt == $past(cnt) + DW'(1)));

  p_ovf_gated_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_en_i |-> !ovf_o);

  p_reload_sub_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && acc[DW-1] && !wr_en_i) |=>
      (cnt == $past(sub)) && (acc == $past(acc) + $past(pos)));

  p_reload_ovr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !acc[DW-1] && !wr_en_i) |=>
      (cnt == $past(ovr)) && (acc == $past(acc) + $past(neg)));

  p_sw_acc_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADR_ACC) |=> (acc == $past(wdata_i)));

  p_hold_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_en_i && !wr_en_i) |=> ($stable(cnt) && $stable(acc)));
endmodule

bind frac_tick_gen frac_tick_sva #(.DW(DW)) u_sva (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_en_i (tick_en_i),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .ovf_o     (ovf_o),
  .cnt       (cnt_val),
  .acc       (acc_val),
  .pos       (pos_inc),
  .neg       (neg_inc),
  .sub       (sub_val),
  .ovr       (ovr_val)
);

// File: tb/tb_frac_tick_gen.sv
module tb_frac_tick_gen;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int N_CFG = 3;
  localparam int N_OVF = 6;

  // {pos, neg, acc start, short start, long start}
  localparam logic [5*DW-1:0] VEC [N_CFG] = '{
    {32'h0000_0001, 32'hFFFF_FFFD, 32'h0000_0000, 32'hFFFF_FFFC, 32'hFFFF_FFFB},
    {32'h0000_0010, 32'hFFFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFD, 32'hFFFF_FFF9},
    {32'h0000_0002, 32'hFFFF_FFFE, 32'h0000_0005, 32'hFFFF_FFFE, 32'hFFFF_FFFA}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_en = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    addr = 3'd0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          ovf;

  int checks = 0;
  int fails = 0;

  frac_tick_gen #(.DW(DW)) dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .tick_en_i (tick_en),
    .wr_en_i   (wr_en),
    .addr_i    (addr),
    .wdata_i   (wdata),
    .rdata_o   (rdata),
    .ovf_o     (ovf)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    logic [DW-1:0] v, e_acc, e_cnt;
    logic [DW-1:0] c_pos, c_neg, c_sub, c_ovr;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      check("R1", v, '0);
    end
    check("R1 ovf", {31'd0, ovf}, '0);
    rst_n = 1'b1;

    // Table walk: R5/R6 ordering under three accumulator patterns
    for (int t = 0; t < N_CFG; t++) begin
      {c_pos, c_neg, e_acc, c_sub, c_ovr} = VEC[t];
      tick_en = 1'b0;
      wr(3'd0, c_pos);
      wr(3'd1, c_neg);
      wr(3'd2, e_acc);
      wr(3'd3, c_sub);
      wr(3'd4, c_ovr);
      wr(3'd5, '1);
      rd(3'd0, v); check("R2 pos", v, c_pos);
      rd(3'd4, v); check("R2 ovr", v, c_ovr);
      @(negedge clk);
      tick_en = 1'b1;
      #1;
      for (int k = 0; k < N_OVF; k++) begin
        for (int n = 0; n < 40 && !ovf; n++) begin
          @(negedge clk);
          #1;
        end
        check("R4 ovf seen", {31'd0, ovf}, 32'd1);
        if (e_acc[DW-1]) begin
          e_acc = e_acc + c_pos; e_cnt = c_sub;
        end else begin
          e_acc = e_acc + c_neg; e_cnt = c_ovr;
        end
        @(negedge clk);
        rd(3'd5, v); check(e_cnt == c_sub ? "R5 cnt" : "R6 cnt", v, e_cnt);
        rd(3'd2, v); check(e_cnt == c_sub ? "R5 acc" : "R6 acc", v, e_acc);
        check("R4 no ovf after reload", {31'd0, ovf}, '0);
      end
      tick_en = 1'b0;
    end

    // R3 counting and R8 hold
    wr(3'd5, 32'h10);
    wr(3'd2, 32'h77);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (3) @(negedge clk);
    tick_en = 1'b0;
    rd(3'd5, v); check("R3 step", v, 32'h13);
    repeat (4) @(negedge clk);
    rd(3'd5, v); check("R8 cnt hold", v, 32'h13);
    rd(3'd2, v); check("R8 acc hold", v, 32'h77);

    // R4/R8: all-ones with enable low gives no pulse and no reload
    wr(3'd5, '1);
    #1;
    check("R4 gated", {31'd0, ovf}, '0);
    repeat (2) @(negedge clk);
    rd(3'd5, v); check("R8 max hold", v, '1);

    // R7 accumulator write collides with overflow
    wr(3'd4, 32'hFFFF_FFF0);
    wr(3'd2, 32'h0);
    @(negedge clk);
    tick_en = 1'b1; wr_en = 1'b1; addr = 3'd2; wdata = 32'h1234;
    @(negedge clk);
    tick_en = 1'b0; wr_en = 1'b0;
    rd(3'd2, v); check("R7 acc write wins", v, 32'h1234);
    rd(3'd5, v); check("R6 reload with acc write", v, 32'hFFFF_FFF0);

    // R7 counter write collides with overflow
    wr(3'd5, '1);
    @(negedge clk);
    tick_en = 1'b1; wr_en = 1'b1; addr = 3'd5; wdata = 32'h100;
    @(negedge clk);
    tick_en = 1'b0; wr_en = 1'b0;
    rd(3'd5, v); check("R7 cnt write wins", v, 32'h100);

    // R2 unmapped addresses
    wr(3'd6, 32'hDEAD_BEEF);
    wr(3'd7, 32'hCAFE_F00D);
    rd(3'd6, v); check("R2 addr6 zero", v, '0);
    rd(3'd7, v); check("R2 addr7 zero", v, '0);
    rd(3'd0, v); check("R2 pos untouched", v, 32'h2);
    rd(3'd3, v); check("R2 sub untouched", v, 32'hFFFF_FFFE);
    rd(3'd5, v); check("R2 cnt untouched", v, 32'h100);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule